// File: doc/BRIEF.md
# Debounced Wake-up Source Controller

This block decides when a sleeping system should wake up. Everything runs on the slow clock. It watches one active-low force-wake pin, a bank of general wake pins, and two alarm inputs that arrive already synchronised, one from the real-time clock and one from the brownout detector. Each source has its own enable. Each general pin can be set to wake on a falling edge or on a rising edge.

The force-wake pin and the general pins each have their own debounce setting, taken from a shared ladder of five lengths. A change counts only once the new level has been sampled without a break for the selected number of cycles. When a source qualifies, the block raises a one-cycle wake request and sets that source's bit in a sticky status register. Reading the status register clears it. A dedicated clear input also clears it.

Software sets the block up through a small register interface: a write strobe, a read strobe, a 2-bit address and 32-bit data.

Top module: `wake_src_ctrl`

## Requirements
- R1: After reset, wake_req is 0 and all three registers read back as 0. All features are disabled and both debounce codes are 0.
- R2: When enabled (ctrl bit 0), a low level on fwake_n produces a wake. With no debounce, wake_req is high in the third cycle after the pin changes. With length N, it is high in cycle N+2. When disabled, the pin never causes a wake.
- R3: Debounce codes 1, 2, 3, 4 and 5 select 3, 32, 512, 4096 and 32768 cycles. Codes 0, 6 and 7 mean no debounce, which behaves as a length of 1.
- R4: General pin i can cause a wake only while its enable bit is set (reg 1 bit i). A disabled pin sets no status bit and raises no wake.
- R5: Polarity bit i (reg 1 bit 16+i) selects the waking edge. A value of 0 wakes on high-to-low and a value of 1 wakes on low-to-high. The opposite edge is ignored.
- R6: The general pins share one debounce code (ctrl bits 10:8). This code is independent of the force-wake code (ctrl bits 6:4).
- R7: A return to the old level before the count completes restarts the count. The wake then comes N+2 cycles after the last change.
- R8: The RTC alarm (ctrl bit 1) and the brownout alarm (ctrl bit 2) each wake on their rising edge when enabled. The wake comes one cycle after the edge. An input held high gives only one wake.
- R9: Status (reg 2) is sticky, with bit 0 for force, bit 1 for RTC, bit 2 for brownout, and bits 16+i for the pins. It is cleared by a read of reg 2 or by stat_clr. A new event in the clearing cycle stays set.
- R10: wake_req is a one-cycle pulse per event. A force-wake pin held low wakes only once until it returns high.
- R11: Register 0 holds the controls, register 1 holds the pin enables in bits 15:0 and the polarities in bits 31:16, and register 2 holds the status. cfg_rdata is combinational on cfg_addr, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (clears status when the address is 2) |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data |
| fwake_n | input | 1 | Asynchronous force-wake pin, active low |
| wk_pin | input | NPIN | Asynchronous general wake pins |
| rtc_alarm | input | 1 | Synchronised RTC alarm |
| bod_alarm | input | 1 | Synchronised brownout alarm |
| stat_clr | input | 1 | Clears the sticky status |
| wake_req | output | 1 | One-cycle wake request |

## Verification
A per-pin debounce counter or accepted level that goes wrong shows up as a wake that arrives at the wrong cycle count, or as a wake on the wrong edge. The bench therefore measures the exact latency from the moment a pin changes to the wake pulse, rather than only checking that a wake occurred. A stale accepted level hides the next genuine edge, so a later wake goes missing or a spurious one appears. The sticky status is read back after every event, which exposes a bit that is set, lost or attributed to the wrong source within one register read.

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl #(
  parameter int NPIN = 16,
  parameter int L1 = 3,
  parameter int L2 = 32,
  parameter int L3 = 512,
  parameter int L4 = 4096,
  parameter int L5 = 32768
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_re,
  input  logic [1:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            fwake_n,
  input  logic [NPIN-1:0] wk_pin,
  input  logic            rtc_alarm,
  input  logic            bod_alarm,
  input  logic            stat_clr,
  output logic            wake_req
);
  localparam int CW = $clog2(L5 + 1);
  localparam int SW = NPIN + 3;

  function automatic logic [CW-1:0] dlen(input logic [2:0] c);
    case (c)
      3'd1: dlen = CW'(L1);
      3'd2: dlen = CW'(L2);
      3'd3: dlen = CW'(L3);
      3'd4: dlen = CW'(L4);
      3'd5: dlen = CW'(L5);
      default: dlen = CW'(1);
    endcase
  endfunction

  logic f_en, r_en, b_en;
  logic [2:0] f_code, p_code;
  logic [NPIN-1:0] p_en, p_rise;
  logic [SW-1:0] st;
  logic [NPIN:0] s1, s2;
  logic r_q, b_q;
  logic [NPIN-1:0] p_hit;
  logic f_hit, r_hit, b_hit;
  logic [SW-1:0] hits;

  wire [CW-1:0] f_len = dlen(f_code);
  wire [CW-1:0] p_len = dlen(p_code);
  wire rd_clr = (cfg_re && cfg_addr == 2'd2) || stat_clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f_en <= 1'b0; r_en <= 1'b0; b_en <= 1'b0;
      f_code <= 3'd0; p_code <= 3'd0;
      p_en <= '0; p_rise <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == 2'd0) begin
        f_en <= cfg_wdata[0];
        r_en <= cfg_wdata[1];
        b_en <= cfg_wdata[2];
        f_code <= cfg_wdata[6:4];
        p_code <= cfg_wdata[10:8];
      end else if (cfg_addr == 2'd1) begin
        p_en <= cfg_wdata[NPIN-1:0];
        p_rise <= cfg_wdata[16 +: NPIN];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1; s2 <= '1;
    end else begin
      s1 <= {fwake_n, wk_pin};
      s2 <= s1;
    end

  logic [CW-1:0] f_cnt;
  logic f_done;
  wire f_arm = f_en && !s2[NPIN] && !f_done;
  assign f_hit = f_arm && (f_cnt >= f_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f_cnt <= '0; f_done <= 1'b0;
    end else begin
      f_cnt <= (!f_arm || f_hit) ? '0 : f_cnt + 1'b1;
      f_done <= f_en && !s2[NPIN] && (f_done || f_hit);
    end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [CW-1:0] cnt;
    logic lvl;
    wire diff = s2[i] != lvl;
    wire acc = diff && (cnt >= p_len - 1'b1);
    assign p_hit[i] = acc && p_en[i] && (s2[i] == p_rise[i]);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0; lvl <= 1'b1;
      end else begin
        cnt <= (!diff || acc) ? '0 : cnt + 1'b1;
        if (acc) lvl <= s2[i];
      end

    p_pin_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st[3+i]) |-> $past(p_en[i]));
    p_dbc_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(st[3+i]) && $past(p_code) >= 3'd1 && $past(p_code) <= 3'd5)
        |-> $past(s2[i]) == $past(s2[i], 2));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_q <= 1'b0; b_q <= 1'b0;
    end else begin
      r_q <= rtc_alarm; b_q <= bod_alarm;
    end

  assign r_hit = r_en && rtc_alarm && !r_q;
  assign b_hit = b_en && bod_alarm && !b_q;
  assign hits = {p_hit, b_hit, r_hit, f_hit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= '0; wake_req <= 1'b0;
    end else begin
      st <= (rd_clr ? '0 : st) | hits;
      wake_req <= |hits;
    end

  always_comb
    case (cfg_addr)
      2'd0: cfg_rdata = {21'd0, p_code, 1'b0, f_code, 1'b0, b_en, r_en, f_en};
      2'd1: cfg_rdata = {16'(p_rise), 16'(p_en)};
      2'd2: cfg_rdata = {16'(st[SW-1:3]), 13'd0, st[2:0]};
      default: cfg_rdata = 32'd0;
    endcase

  p_req_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> st != '0);
  p_clr_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_clr) && !wake_req) |-> st == '0);
  p_force_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[0]) |-> (!$past(s2[NPIN]) && $past(f_en)));
endmodule

// File: tb/wake_src_ctrl_tb.sv
module wake_src_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_re = 0;
  logic [1:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic fwake_n = 1;
  logic [15:0] wk_pin = 16'hFFFF;
  logic rtc_alarm = 0, bod_alarm = 0, stat_clr = 0;
  logic wake_req;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  wake_src_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fwake_n(fwake_n), .wk_pin(wk_pin), .rtc_alarm(rtc_alarm),
    .bod_alarm(bod_alarm), .stat_clr(stat_clr), .wake_req(wake_req));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int dlen(input int c);
    case (c)
      1: return 3; 2: return 32; 3: return 512; 4: return 4096; 5: return 32768;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_re = 1; cfg_addr = a; #1 d = cfg_rdata;
    @(negedge clk); cfg_re = 0;
  endtask

  task automatic wait_wake(input int lim, output int n);
    n = -1;
    for (int k = 1; k <= lim; k++) begin
      @(posedge clk); #1;
      if (wake_req) begin n = k; break; end
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  logic [31:0] d;
  int n;
  logic [15:0] pen, prise;

  initial begin
    idle(4);
    rst_n = 1;
    idle(2);
    chk("R1 wake_req", wake_req, 0);
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 pins", d, 0);
    rd(2, d); chk("R1 status", d, 0);

    wr(1, 32'hA5A5_00FF); rd(1, d); chk("R11 reg1", d, 32'hA5A5_00FF);
    wr(0, 32'h0000_0537); rd(0, d); chk("R11 reg0", d, 32'h0000_0537);
    wr(1, 0); wr(0, 0);

    wr(0, 32'h1);
    @(negedge clk); fwake_n = 0; wait_wake(8, n); chk("R2 force latency", n, 3);
    wait_wake(12, n); chk("R10 single force wake", n, -1);
    rd(2, d); chk("R9 force status", d, 1);
    rd(2, d); chk("R9 clear on read", d, 0);
    @(negedge clk); fwake_n = 1; idle(4);

    @(negedge clk); fwake_n = 0; wait_wake(8, n); chk("R10 rearm after high", n, 3);
    @(negedge clk); fwake_n = 1; idle(4);

    foreach (d[i]) if (i < 8) begin end
    for (int c = 1; c <= 7; c++) begin
      wr(0, 32'h1 | (c << 4));
      @(negedge clk); fwake_n = 0;
      wait_wake(dlen(c) + 6, n); chk($sformatf("R3 force code %0d", c), n, dlen(c) + 2);
      @(negedge clk); fwake_n = 1; idle(4);
    end
    rd(2, d);

    wr(0, 32'h0);
    @(negedge clk); fwake_n = 0; wait_wake(20, n); chk("R2 force disabled", n, -1);
    @(negedge clk); fwake_n = 1; idle(4);

    wr(0, 32'h0000_0021); wr(1, 32'h1);
    @(negedge clk); fwake_n = 0; wait_wake(40, n); chk("R6 force code 2", n, 34);
    @(negedge clk); wk_pin[0] = 0; wait_wake(8, n); chk("R6 pin code 0", n, 3);
    rd(2, d); chk("R6 status", d, 32'h0001_0001);
    @(negedge clk); fwake_n = 1; wk_pin[0] = 1; idle(6);

    wr(0, 32'h0000_0200);
    @(negedge clk); wk_pin[0] = 0; wait_wake(10, n); chk("R7 bounce low", n, -1);
    @(negedge clk); wk_pin[0] = 1; wait_wake(10, n); chk("R7 bounce high", n, -1);
    @(negedge clk); wk_pin[0] = 0; wait_wake(40, n); chk("R7 restart latency", n, 34);
    rd(2, d); chk("R7 status", d, 32'h0001_0000);
    @(negedge clk); wk_pin[0] = 1; idle(40);

    wr(0, 0); wr(1, 32'h0008_0008);
    @(negedge clk); wk_pin[3] = 0; wait_wake(8, n); chk("R5 falling ignored", n, -1);
    @(negedge clk); wk_pin[3] = 1; wait_wake(8, n); chk("R5 rising wakes", n, 3);
    rd(2, d); chk("R5 status", d, 32'h0008_0000);
    wr(1, 0);

    wr(0, 32'h2);
    @(negedge clk); rtc_alarm = 1; wait_wake(4, n); chk("R8 rtc latency", n, 1);
    wait_wake(6, n); chk("R8 rtc held once", n, -1);
    @(negedge clk); bod_alarm = 1; wait_wake(6, n); chk("R8 bod disabled", n, -1);
    rd(2, d); chk("R8 rtc status", d, 2);
    @(negedge clk); rtc_alarm = 0; bod_alarm = 0;
    wr(0, 32'h4);
    @(negedge clk); bod_alarm = 1; wait_wake(4, n); chk("R8 bod latency", n, 1);
    rd(2, d); chk("R8 bod status", d, 4);
    @(negedge clk); bod_alarm = 0;

    wr(0, 32'h2);
    @(negedge clk); rtc_alarm = 1; stat_clr = 1;
    @(negedge clk); stat_clr = 0; rtc_alarm = 0;
    rd(2, d); chk("R9 set wins over clear", d, 2);
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0;
    rd(2, d); chk("R9 stat_clr", d, 0);

    for (int it = 0; it < 40; it++) begin
      int pin, code, lat;
      logic nv, exp_w;
      pin = $urandom % 16;
      code = $urandom % 3;
      pen = 16'($urandom); prise = 16'($urandom);
      wr(0, code << 8); wr(1, {prise, pen});
      nv = ~wk_pin[pin];
      exp_w = pen[pin] && (nv == prise[pin]);
      lat = dlen(code) + 2;
      @(negedge clk); wk_pin[pin] = nv;
      wait_wake(lat + 4, n);
      chk($sformatf("R4 R5 rand pin %0d", pin), n, exp_w ? lat : -1);
      idle(4);
      rd(2, d);
      chk("R4 rand status", d, exp_w ? (32'h1 << (16 + pin)) : 32'h0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial $urandom(32'h5EED);
endmodule